// File: doc/BRIEF.md
# Barker Chip-Timing Despreader

This block takes a stream of signed I/Q samples at one sample per chip and correlates every new sample, together with the ten samples before it, against the 11-chip Barker spreading code. Each correlator output produces a magnitude estimate, |I|+|Q|. During a search window the estimate is added into one of eleven accumulators, chosen by the sample's chip position within the window. When the window closes, the position with the largest total becomes the symbol timing. After that, the block passes exactly one I/Q correlation value per symbol downstream, taken at the chosen position.

A search starts with a one-cycle `dwell_start` pulse. Signal arrival has no fixed relation to the window, so every pulse throws away the old totals and the old lock and begins a fresh integration. The sample history held by the correlator is not cleared by the pulse. The chosen timing and its peak total stay on the outputs until the next pulse.

Both data sides use valid/ready. An input sample transfers on a clock edge where `s_valid` and `s_ready` are both high. A symbol transfers on an edge where `m_valid` and `m_ready` are both high. A symbol that has been offered stays valid and unchanged until it is taken. While it waits, the input side is held off, so no sample is ever lost.

Top module: `barker_timing_despreader`

## Requirements
- R1: For every accepted sample the correlation is sum over j=0..10 of w[j]*x[j]. x[10] is the newest sample, x[0] is the sample ten accepted samples earlier, and w = +1,-1,+1,+1,-1,+1,+1,+1,-1,-1,-1 for j = 0..10. This is done for I and Q separately. The history is zero after reset and is not cleared by `dwell_start`.
- R2: A window covers 11*DWELL_SYMS accepted samples, counted from the one accepted in the `dwell_start` cycle (or the first one after it). Sample k of the window adds |corr_i|+|corr_q| to the total of phase k mod 11. When the lock rises, `peak_mag` equals the largest of the eleven totals.
- R3: `timing_phase` is the index (0..10) of the largest total. When totals are equal, the lowest index wins.
- R4: In the cycle after the last sample of a window is accepted, `s_ready` is low and `timing_locked` is still low. In the cycle after that, `timing_locked` is high.
- R5: `dwell_start` drops `timing_locked` on the next cycle and cancels a pick that is pending. Without a new pulse, `timing_phase` and `peak_mag` hold their values.
- R6: While locked, each accepted sample whose phase (counting continues mod 11 after the window) equals `timing_phase` yields one output symbol whose `m_i`/`m_q` are that sample's correlations, visible the next cycle. No other sample yields an output.
- R7: While `m_valid` is high and `m_ready` is low, `m_valid`, `m_i` and `m_q` hold and `s_ready` is low.
- R8: After reset, `m_valid`, `timing_locked`, `timing_phase` and `peak_mag` are zero and `s_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dwell_start | input | 1 | Pulse that begins a new search window |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Input sample accepted when high |
| s_i | input | IW | Signed in-phase sample |
| s_q | input | IW | Signed quadrature sample |
| m_valid | output | 1 | Output symbol valid |
| m_ready | input | 1 | Downstream takes the symbol when high |
| m_i | output | IW+4 | Signed in-phase correlation at the symbol instant |
| m_q | output | IW+4 | Signed quadrature correlation at the symbol instant |
| timing_phase | output | 4 | Chosen chip phase, 0..10 |
| peak_mag | output | IW+5+clog2(DWELL_SYMS+1) | Largest phase total of the last window |
| timing_locked | output | 1 | A timing decision is valid |

## Verification
Two events can meet in one cycle, and the bench provokes both.

The first is a `dwell_start` that coincides with the first sample of a window. The sample is driven with the pulse high and must count as phase 0 of the new window. The chosen phase from a signal with known offset shows whether it did.

The second is a `dwell_start` in the single cycle after a window's last sample, while the pick is pending. The bench drives the pulse on exactly that cycle and expects `timing_locked` to stay low.

Throughout both cases, random back-pressure on `m_ready` competes with incoming samples. The symbol stream is compared value by value against a reference model.

// File: rtl/barker_desp_pkg.sv
package barker_desp_pkg;
  localparam int CHIPS = 11;
  localparam int PHW   = 4;
  // tap weight per position, bit j set = +1, position 10 is the newest sample
  localparam logic [CHIPS-1:0] CODE = 11'b00011101101;
  localparam logic [PHW-1:0]  LAST_PHASE = PHW'(CHIPS - 1);
endpackage

// File: rtl/barker_corr.sv
module barker_corr
  import barker_desp_pkg::*;
#(
  parameter int IW = 8,
  localparam int CW = IW + 4,
  localparam int MW = CW + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic signed [IW-1:0] in_i,
  input  logic signed [IW-1:0] in_q,
  output logic signed [CW-1:0] corr_i,
  output logic signed [CW-1:0] corr_q,
  output logic        [MW-1:0] mag
);
  localparam int DEPTH = CHIPS - 1;

  logic signed [IW-1:0] hist_i [DEPTH];
  logic signed [IW-1:0] hist_q [DEPTH];
  logic signed [CW-1:0] tap_i  [CHIPS];
  logic signed [CW-1:0] tap_q  [CHIPS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) begin
        hist_i[j] <= '0;
        hist_q[j] <= '0;
      end
    end else if (shift_en) begin
      for (int j = 0; j < DEPTH - 1; j++) begin
        hist_i[j] <= hist_i[j+1];
        hist_q[j] <= hist_q[j+1];
      end
      hist_i[DEPTH-1] <= in_i;
      hist_q[DEPTH-1] <= in_q;
    end
  end

  for (genvar j = 0; j < CHIPS; j++) begin : g_tap
    logic signed [CW-1:0] xi, xq;
    if (j == CHIPS - 1) begin : g_new
      assign xi = CW'(in_i);
      assign xq = CW'(in_q);
    end else begin : g_old
      assign xi = CW'(hist_i[j]);
      assign xq = CW'(hist_q[j]);
    end
    assign tap_i[j] = CODE[j] ? xi : -xi;
    assign tap_q[j] = CODE[j] ? xq : -xq;
  end

  logic [CW-1:0] abs_i, abs_q;

  always_comb begin
    corr_i = '0;
    corr_q = '0;
    for (int j = 0; j < CHIPS; j++) begin
      corr_i = corr_i + tap_i[j];
      corr_q = corr_q + tap_q[j];
    end
    abs_i = corr_i[CW-1] ? CW'(-corr_i) : CW'(corr_i);
    abs_q = corr_q[CW-1] ? CW'(-corr_q) : CW'(corr_q);
    mag   = MW'(abs_i) + MW'(abs_q);
  end
endmodule

// File: rtl/phase_bank.sv
module phase_bank
  import barker_desp_pkg::*;
#(
  parameter int MW = 13,
  parameter int AW = 18
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic           add_en,
  input  logic [PHW-1:0] add_phase,
  input  logic [MW-1:0]  add_mag,
  output logic [PHW-1:0] best_phase,
  output logic [AW-1:0]  best_val
);
  logic [AW-1:0] tot [CHIPS];

  for (genvar g = 0; g < CHIPS; g++) begin : g_acc
    logic [AW-1:0] r;
    logic          hit;
    assign hit = add_en && (add_phase == PHW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      r <= '0;
      else if (clr)    r <= hit ? AW'(add_mag) : '0;
      else if (hit)    r <= r + AW'(add_mag);
    end
    assign tot[g] = r;
  end

  // strict compare keeps the lowest index on equal totals
  always_comb begin
    best_val   = tot[0];
    best_phase = '0;
    for (int p = 1; p < CHIPS; p++) begin
      if (tot[p] > best_val) begin
        best_val   = tot[p];
        best_phase = PHW'(p);
      end
    end
  end
endmodule

// File: rtl/barker_timing_despreader.sv
module barker_timing_despreader
  import barker_desp_pkg::*;
#(
  parameter  int IW         = 8,
  parameter  int DWELL_SYMS = 16,
  localparam int CW         = IW + 4,
  localparam int AW         = IW + 5 + $clog2(DWELL_SYMS + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dwell_start,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic signed [IW-1:0] s_i,
  input  logic signed [IW-1:0] s_q,
  output logic                 m_valid,
  input  logic                 m_ready,
  output logic signed [CW-1:0] m_i,
  output logic signed [CW-1:0] m_q,
  output logic [PHW-1:0]       timing_phase,
  output logic [AW-1:0]        peak_mag,
  output logic                 timing_locked
);
  localparam int MW          = CW + 1;
  localparam int DWELL_CHIPS = CHIPS * DWELL_SYMS;
  localparam int DCW         = $clog2(DWELL_CHIPS + 1);

  logic                 take, acc_en, last_chip, emit;
  logic [PHW-1:0]       phase_q, cur_phase, best_phase;
  logic [DCW-1:0]       dcnt_q, cur_dcnt;
  logic                 in_dwell_q, pick_pend_q;
  logic signed [CW-1:0] corr_i, corr_q;
  logic [MW-1:0]        mag;
  logic [AW-1:0]        best_val;

  assign s_ready   = !pick_pend_q && !(m_valid && !m_ready);
  assign take      = s_valid && s_ready;
  assign cur_phase = dwell_start ? '0 : phase_q;
  assign cur_dcnt  = dwell_start ? '0 : dcnt_q;
  assign acc_en    = take && (dwell_start || in_dwell_q);
  assign last_chip = acc_en && (cur_dcnt == DCW'(DWELL_CHIPS - 1));
  assign emit      = take && timing_locked && !dwell_start && (phase_q == timing_phase);

  barker_corr #(.IW(IW)) u_corr (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (take),
    .in_i     (s_i),
    .in_q     (s_q),
    .corr_i   (corr_i),
    .corr_q   (corr_q),
    .mag      (mag)
  );

  phase_bank #(.MW(MW), .AW(AW)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (dwell_start),
    .add_en     (acc_en),
    .add_phase  (cur_phase),
    .add_mag    (mag),
    .best_phase (best_phase),
    .best_val   (best_val)
  );

  // chip phase and window sequencing
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= '0;
      dcnt_q      <= '0;
      in_dwell_q  <= 1'b0;
      pick_pend_q <= 1'b0;
    end else begin
      if (take)             phase_q <= (cur_phase == LAST_PHASE) ? '0 : cur_phase + 1'b1;
      else if (dwell_start) phase_q <= '0;

      if (acc_en)           dcnt_q <= cur_dcnt + 1'b1;
      else if (dwell_start) dcnt_q <= '0;

      if (last_chip)        in_dwell_q <= 1'b0;
      else if (dwell_start) in_dwell_q <= 1'b1;

      pick_pend_q <= last_chip;
    end
  end

  // timing decision
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      timing_locked <= 1'b0;
      timing_phase  <= '0;
      peak_mag      <= '0;
    end else if (dwell_start) begin
      timing_locked <= 1'b0;
    end else if (pick_pend_q) begin
      timing_locked <= 1'b1;
      timing_phase  <= best_phase;
      peak_mag      <= best_val;
    end
  end

  // symbol output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_i     <= '0;
      m_q     <= '0;
    end else if (emit) begin
      m_valid <= 1'b1;
      m_i     <= corr_i;
      m_q     <= corr_q;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/barker_timing_despreader_chk.sv
module barker_timing_despreader_chk
  import barker_desp_pkg::*;
#(
  parameter  int IW         = 8,
  parameter  int DWELL_SYMS = 16,
  localparam int CW         = IW + 4,
  localparam int AW         = IW + 5 + $clog2(DWELL_SYMS + 1)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dwell_start,
  input logic                 s_valid,
  input logic                 s_ready,
  input logic signed [IW-1:0] s_i,
  input logic signed [IW-1:0] s_q,
  input logic                 m_valid,
  input logic                 m_ready,
  input logic signed [CW-1:0] m_i,
  input logic signed [CW-1:0] m_q,
  input logic [PHW-1:0]       timing_phase,
  input logic [AW-1:0]        peak_mag,
  input logic                 timing_locked
);
  assert_out_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_i) && $stable(m_q)));

  assert_in_stall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);

  assert_phase_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    timing_locked |-> (timing_phase < PHW'(CHIPS)));

  assert_timing_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_locked && !dwell_start) |=>
      (timing_locked && $stable(timing_phase) && $stable(peak_mag)));

  assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dwell_start |=> !timing_locked);

  assert_no_out_unlocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && !timing_locked) |=> !$rose(m_valid));

  assert_lock_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(timing_locked)) |-> $past(!s_ready));
endmodule

bind barker_timing_despreader barker_timing_despreader_chk #(
  .IW(IW), .DWELL_SYMS(DWELL_SYMS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .dwell_start(dwell_start),
  .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
  .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
  .timing_phase(timing_phase), .peak_mag(peak_mag), .timing_locked(timing_locked)
);

// File: tb/barker_timing_despreader_tb.sv
module barker_timing_despreader_tb;
  localparam int IW = 8;
  localparam int DS = 16;
  localparam int CW = IW + 4;
  localparam int AW = IW + 5 + $clog2(DS + 1);
  localparam int NCH = 11 * DS;

  logic clk = 0, rst_n = 0, dwell_start = 0, s_valid = 0, m_ready = 1;
  logic signed [IW-1:0] s_i = 0, s_q = 0;
  logic s_ready, m_valid, timing_locked;
  logic signed [CW-1:0] m_i, m_q;
  logic [3:0] timing_phase;
  logic [AW-1:0] peak_mag;

  always #4 clk = ~clk;

  barker_timing_despreader #(.IW(IW), .DWELL_SYMS(DS)) u_dut (
    .clk(clk), .rst_n(rst_n), .dwell_start(dwell_start),
    .s_valid(s_valid), .s_ready(s_ready), .s_i(s_i), .s_q(s_q),
    .m_valid(m_valid), .m_ready(m_ready), .m_i(m_i), .m_q(m_q),
    .timing_phase(timing_phase), .peak_mag(peak_mag), .timing_locked(timing_locked));

  int nchk = 0, nerr = 0;
  int BK [11] = '{1, -1, 1, 1, -1, 1, 1, 1, -1, -1, -1};
  int hi [10], hq [10], acc [11];
  int mph = 0, mdcnt = 0, mtp = 0, mpeak = 0;
  bit mindw = 0, mlocked = 0, bp_en = 0;
  int exp_i [$], exp_q [$];
  int n_rx = 0;
  int g_k = 0, g_off = 1000000, g_amp = 0, g_noise = 0, g_bi = 1, g_bq = 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic void model_restart();
    for (int p = 0; p < 11; p++) acc[p] = 0;
    mlocked = 0; mph = 0; mdcnt = 0; mindw = 1;
  endfunction

  function automatic void model_accept(input int i, input int q, input bit ds);
    int ci, cq;
    if (ds) model_restart();
    ci = BK[10] * i;
    cq = BK[10] * q;
    for (int j = 0; j < 10; j++) begin
      ci += BK[j] * hi[j];
      cq += BK[j] * hq[j];
    end
    if (mindw) begin
      acc[mph] += iabs(ci) + iabs(cq);
      mdcnt++;
      if (mdcnt == NCH) begin
        mindw = 0; mlocked = 1; mtp = 0; mpeak = acc[0];
        for (int p = 1; p < 11; p++)
          if (acc[p] > mpeak) begin mpeak = acc[p]; mtp = p; end
      end
    end else if (mlocked && mph == mtp) begin
      exp_i.push_back(ci);
      exp_q.push_back(cq);
    end
    for (int j = 0; j < 9; j++) begin hi[j] = hi[j+1]; hq[j] = hq[j+1]; end
    hi[9] = i; hq[9] = q;
    mph = (mph + 1) % 11;
  endfunction

  function automatic int clip(input int v);
    return v > 127 ? 127 : (v < -128 ? -128 : v);
  endfunction

  task automatic next_sample(output int i, output int q);
    int ni, nq, ch;
    ni = int'($urandom % (2 * g_noise + 1)) - g_noise;
    nq = int'($urandom % (2 * g_noise + 1)) - g_noise;
    if (g_k < g_off) begin
      i = ni; q = nq;
    end else begin
      ch = (g_k - g_off) % 11;
      if (ch == 0) begin
        g_bi = ($urandom % 2) ? 1 : -1;
        g_bq = ($urandom % 2) ? 1 : -1;
      end
      i = clip(g_bi * g_amp * BK[ch] + ni);
      q = clip(g_bq * g_amp * BK[ch] + nq);
    end
    g_k++;
  endtask

  task automatic send(input int i, input int q, input bit ds);
    @(negedge clk);
    s_valid = 1; s_i = IW'(i); s_q = IW'(q); dwell_start = ds;
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    model_accept(i, q, ds);
    #1;
    s_valid = 0; dwell_start = 0;
  endtask

  task automatic send_gen(input int n, input bit ds_first);
    int i, q;
    for (int k = 0; k < n; k++) begin
      next_sample(i, q);
      send(i, q, ds_first && k == 0);
    end
  endtask

  task automatic check_lock(input string tag, input int want_phase);
    @(negedge clk);
    check(!s_ready && !timing_locked, {tag, " R4 gap"}, {s_ready, timing_locked}, 0);
    @(negedge clk);
    check(timing_locked, {tag, " R4 lock"}, timing_locked, 1);
    check(timing_phase == 4'(mtp), {tag, " R3 phase vs model"}, timing_phase, mtp);
    check(peak_mag == AW'(mpeak), {tag, " R2 peak"}, peak_mag, mpeak);
    if (want_phase >= 0)
      check(timing_phase == 4'(want_phase), {tag, " R1 directed phase"}, timing_phase, want_phase);
  endtask

  always @(posedge clk) begin
    #1;
    m_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
  end

  bit prev_stall = 0;
  logic signed [CW-1:0] prev_i, prev_q;
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)
        check(m_valid && m_i == prev_i && m_q == prev_q, "R7 hold", m_i, prev_i);
      if (m_valid && m_ready) begin
        n_rx++;
        if (exp_i.size() == 0) begin
          check(0, "R6 unexpected symbol", m_i, 0);
        end else begin
          check(m_i == CW'(exp_i[0]) && m_q == CW'(exp_q[0]), "R1/R6 symbol", m_i, exp_i[0]);
          void'(exp_i.pop_front());
          void'(exp_q.pop_front());
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_i = m_i; prev_q = m_q;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd4099));
    for (int j = 0; j < 10; j++) begin hi[j] = 0; hq[j] = 0; end
    for (int p = 0; p < 11; p++) acc[p] = 0;
    repeat (3) @(negedge clk);
    check(!m_valid && !timing_locked && s_ready && timing_phase == 0 && peak_mag == 0,
          "R8 reset state", {m_valid, timing_locked, s_ready}, 1);
    rst_n = 1;
    @(negedge clk);

    // A: noise lead-in, then signal offset 4 in the window
    g_noise = 10; g_off = 1000000; g_k = 0;
    send_gen(7, 0);
    g_k = 0; g_off = 4; g_amp = 20; g_noise = 3;
    send_gen(NCH, 1);
    check_lock("A", (4 + 10) % 11);
    n_rx = 0; bp_en = 1;
    send_gen(88, 0);
    bp_en = 0;
    repeat (6) @(negedge clk);
    check(n_rx == 8, "R6 one symbol per 11", n_rx, 8);
    check(exp_i.size() == 0, "R6 queue drained", exp_i.size(), 0);
    check(timing_phase == 4'(mtp) && timing_locked, "R5 held", timing_phase, mtp);

    // B: all-zero window after flushing history, all totals tie
    for (int k = 0; k < 10; k++) send(0, 0, 0);
    for (int k = 0; k < NCH; k++) send(0, 0, k == 0);
    check_lock("B tie", 0);
    check(peak_mag == 0, "R3 tie peak", peak_mag, 0);

    // C: pending pick cancelled by dwell_start
    g_k = 0; g_off = 1000000; g_noise = 40;
    send_gen(NCH, 1);
    @(negedge clk);
    dwell_start = 1;
    @(posedge clk);
    model_restart();
    #1 dwell_start = 0;
    @(negedge clk);
    check(!timing_locked, "R5 cancel pending pick", timing_locked, 0);

    // D: strong signal aligned to window start, back-pressure throughout
    g_k = 0; g_off = 0; g_amp = 90; g_noise = 20;
    bp_en = 1;
    send_gen(NCH, 1);
    check_lock("D", 10);
    n_rx = 0;
    send_gen(33, 0);
    bp_en = 0;
    repeat (6) @(negedge clk);
    check(n_rx == 3, "R6 count under back-pressure", n_rx, 3);
    check(exp_i.size() == 0, "R6 queue drained D", exp_i.size(), 0);

    // E: restart drops lock on the next cycle
    @(negedge clk);
    dwell_start = 1;
    @(posedge clk);
    model_restart();
    #1 dwell_start = 0;
    @(negedge clk);
    check(!timing_locked, "R5 restart clears lock", timing_locked, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule